// File: doc/BRIEF.md
# Parallel RGB Panel Sync and Data-Enable Generator

This block runs on the pixel clock of a parallel RGB panel. It produces the active-low horizontal and vertical sync pulses, a data-enable flag that marks valid pixels, the active-area column and row of the current pixel, and a one-clock frame-start pulse. One of three built-in resolution profiles is chosen by parameter. The individual timing figures can also be overridden.

Each line starts with a one-clock horizontal sync pulse, which is counted as the first clock of the back porch. Active pixels come next, followed by the front porch. Frames follow the same pattern in units of lines, with a vertical sync that lasts one whole line.

A pixel-request strobe runs exactly one clock ahead of data enable. An upstream frame buffer with one cycle of read latency can use it to present RGB data in the same cycle that data enable is high. All outputs leave registers clocked on the same edge, so they stay aligned with each other.

Top module: `panel_timing_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `hsync_n` and `vsync_n` are 1, and `de`, `pix_req`, `frame_start`, `pix_x` and `pix_y` are 0.
- R2: Number the clocks after reset release as positions p = 0, 1, 2, ..., with column x = p mod H_TOTAL. The outputs registered on the edge that follows reset release describe position 0. `hsync_n` is 0 exactly when x = 0, so it is low for one clock every H_TOTAL clocks.
- R3: With line y = (p div H_TOTAL) mod V_TOTAL, `vsync_n` is 0 for every clock of line y = 0 and is 1 on every other line.
- R4: `de` is 1 exactly when H_BP <= x < H_TOTAL-H_FP and V_BP <= y < V_TOTAL-V_FP. The sync clock or line is counted inside the back porch, so `de` is never high during a sync.
- R5: `pix_req` at position p equals `de` at position p+1.
- R6: `frame_start` is 1 for exactly one clock per frame, at x = 0 and y = 0, which is the first clock in which `vsync_n` is low.
- R7: While `de` is 1, `pix_x` = x-H_BP and `pix_y` = y-V_BP. While `de` is 0, both are 0.
- R8: Profile 0 uses 1056/216/40 clocks and 525/35/10 lines. Profile 1 uses 525/43/2 and 286/12/2. Profile 2 uses 528/108/20 and 262/20/2. Each triple is total, back porch, front porch.
- R9: The column counter wraps from H_TOTAL-1 to 0, and the line advances only on that wrap. The line wraps from V_TOTAL-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low, one clock |
| vsync_n | output | 1 | Vertical sync, active low, one line |
| de | output | 1 | Data enable: high during active pixels |
| pix_req | output | 1 | Pixel request, one clock ahead of `de` |
| frame_start | output | 1 | One-clock pulse at the start of vertical sync |
| pix_x | output | $clog2(H_TOTAL) | Active column, 0 outside the active area |
| pix_y | output | $clog2(V_TOTAL) | Active row, 0 outside the active area |

## Verification
Every output is registered one edge after the counter state it decodes. Position p therefore appears at the sample taken after the (p+1)-th edge following reset release. The only exception is `pix_req`, which decodes the next position and so leads `de` by exactly one sample. The bench samples on the falling edge and keeps its own position index. From that index it derives column, line, sync, enable and request arithmetically, using the requirement formulas. It compares every output on every cycle for a reduced custom geometry and for all three built-in profiles, through far enough into the frame to reach the first active line.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;

  function automatic int prof_h_total(input int p);
    case (p)
      0:       return 1056;
      1:       return 525;
      default: return 528;
    endcase
  endfunction

  function automatic int prof_h_bp(input int p);
    case (p)
      0:       return 216;
      1:       return 43;
      default: return 108;
    endcase
  endfunction

  function automatic int prof_h_fp(input int p);
    case (p)
      0:       return 40;
      1:       return 2;
      default: return 20;
    endcase
  endfunction

  function automatic int prof_v_total(input int p);
    case (p)
      0:       return 525;
      1:       return 286;
      default: return 262;
    endcase
  endfunction

  function automatic int prof_v_bp(input int p);
    case (p)
      0:       return 35;
      1:       return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int prof_v_fp(input int p);
    case (p)
      0:       return 10;
      default: return 2;
    endcase
  endfunction

  // Active span test: position lies after the back porch and before the front porch.
  function automatic logic in_span(input int pos, input int bp, input int fp, input int total);
    return (pos >= bp) && (pos < total - fp);
  endfunction

endpackage

// File: rtl/pt_axis_counter.sv
module pt_axis_counter #(
  parameter int TOTAL = 8,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         last
);

  assign last = (cnt == W'(TOTAL - 1));

  always_comb begin
    nxt = cnt;
    if (step) nxt = last ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < TOTAL); // R9

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (cnt == '0)); // R9

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt)); // R9

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
#(
  parameter int PROFILE = 2,
  parameter int H_TOTAL = prof_h_total(PROFILE),
  parameter int H_BP    = prof_h_bp(PROFILE),
  parameter int H_FP    = prof_h_fp(PROFILE),
  parameter int V_TOTAL = prof_v_total(PROFILE),
  parameter int V_BP    = prof_v_bp(PROFILE),
  parameter int V_FP    = prof_v_fp(PROFILE),
  parameter int HW      = $clog2(H_TOTAL),
  parameter int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic          pix_req,
  output logic          frame_start,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y
);

  logic [HW-1:0] hc, hn;
  logic [VW-1:0] vc, vn;
  logic          h_last, v_last;

  // Event wires brought out for the assertions
  logic at_line_start, at_frame_line, cur_active, next_active;

  pt_axis_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .cnt(hc), .nxt(hn), .last(h_last));

  pt_axis_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(h_last), .cnt(vc), .nxt(vn), .last(v_last));

  assign at_line_start = (hc == '0);
  assign at_frame_line = (vc == '0);
  assign cur_active    = in_span(int'(hc), H_BP, H_FP, H_TOTAL) &&
                         in_span(int'(vc), V_BP, V_FP, V_TOTAL);
  assign next_active   = in_span(int'(hn), H_BP, H_FP, H_TOTAL) &&
                         in_span(int'(vn), V_BP, V_FP, V_TOTAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      de          <= 1'b0;
      pix_req     <= 1'b0;
      frame_start <= 1'b0;
      pix_x       <= '0;
      pix_y       <= '0;
    end else begin
      hsync_n     <= !at_line_start;
      vsync_n     <= !at_frame_line;
      de          <= cur_active;
      pix_req     <= next_active;
      frame_start <= at_line_start && at_frame_line;
      pix_x       <= cur_active ? hc - HW'(H_BP) : '0;
      pix_y       <= cur_active ? vc - VW'(V_BP) : '0;
    end
  end

  AST_HSYNC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |=> hsync_n); // R2

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n)); // R4

  AST_REQ_LEADS_DE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> de); // R5

  AST_NO_REQ_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_req && !$isunknown(pix_req) && $past(rst_n)) |=> !de); // R5

  AST_FSTART_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!vsync_n && !hsync_n)); // R6

  AST_PIX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_x == '0 && pix_y == '0)); // R7

  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !h_last |=> $stable(vc)); // R9

endmodule

// File: tb/panel_timing_gen_test.sv
module panel_timing_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // small geometry: 12 clocks/line (bp 3, fp 2), 8 lines/frame (bp 2, fp 1)
  logic s_hs, s_vs, s_de, s_rq, s_fs;
  logic [3:0] s_px;
  logic [2:0] s_py;

  panel_timing_gen #(.H_TOTAL(12), .H_BP(3), .H_FP(2),
                     .V_TOTAL(8), .V_BP(2), .V_FP(1)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_n(s_hs), .vsync_n(s_vs), .de(s_de),
    .pix_req(s_rq), .frame_start(s_fs), .pix_x(s_px), .pix_y(s_py));

  logic a_hs, a_vs, a_de, a_rq, a_fs;
  logic [10:0] a_px;
  logic [9:0]  a_py;
  panel_timing_gen #(.PROFILE(0)) uut_p0 (
    .clk(clk), .rst_n(rst_n), .hsync_n(a_hs), .vsync_n(a_vs), .de(a_de),
    .pix_req(a_rq), .frame_start(a_fs), .pix_x(a_px), .pix_y(a_py));

  logic b_hs, b_vs, b_de, b_rq, b_fs;
  logic [9:0] b_px;
  logic [8:0] b_py;
  panel_timing_gen #(.PROFILE(1)) uut_p1 (
    .clk(clk), .rst_n(rst_n), .hsync_n(b_hs), .vsync_n(b_vs), .de(b_de),
    .pix_req(b_rq), .frame_start(b_fs), .pix_x(b_px), .pix_y(b_py));

  logic c_hs, c_vs, c_de, c_rq, c_fs;
  logic [9:0] c_px;
  logic [8:0] c_py;
  panel_timing_gen #(.PROFILE(2)) uut_p2 (
    .clk(clk), .rst_n(rst_n), .hsync_n(c_hs), .vsync_n(c_vs), .de(c_de),
    .pix_req(c_rq), .frame_start(c_fs), .pix_x(c_px), .pix_y(c_py));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit active_at(input int p, input int ht, input int hbp, input int hfp,
                                   input int vt, input int vbp, input int vfp);
    int x = p % ht;
    int y = (p / ht) % vt;
    return (x >= hbp) && (x < ht - hfp) && (y >= vbp) && (y < vt - vfp);
  endfunction

  task automatic check_pos(input string name, input int p,
                           input int ht, input int hbp, input int hfp,
                           input int vt, input int vbp, input int vfp,
                           input logic hs, input logic vs, input logic de, input logic rq,
                           input logic fs, input int px, input int py);
    int  x = p % ht;
    int  y = (p / ht) % vt;
    bit  act = active_at(p, ht, hbp, hfp, vt, vbp, vfp);
    chk({"R2 ", name}, "hsync_n", int'(hs), (x != 0) ? 1 : 0);
    chk({"R3 ", name}, "vsync_n", int'(vs), (y != 0) ? 1 : 0);
    chk({"R4 ", name}, "de", int'(de), int'(act));
    chk({"R5 ", name}, "pix_req", int'(rq), int'(active_at(p + 1, ht, hbp, hfp, vt, vbp, vfp)));
    chk({"R6 ", name}, "frame_start", int'(fs), (x == 0 && y == 0) ? 1 : 0);
    chk({"R7 ", name}, "pix_x", px, act ? x - hbp : 0);
    chk({"R7 ", name}, "pix_y", py, act ? y - vbp : 0);
  endtask

  task automatic check_reset_state(input string when);
    chk({"R1 ", when}, "hsync_n", int'(s_hs), 1);
    chk({"R1 ", when}, "vsync_n", int'(s_vs), 1);
    chk({"R1 ", when}, "de", int'(s_de), 0);
    chk({"R1 ", when}, "pix_req", int'(s_rq), 0);
    chk({"R1 ", when}, "frame_start", int'(s_fs), 0);
    chk({"R1 ", when}, "pix_x", int'(s_px), 0);
    chk({"R1 ", when}, "pix_y", int'(s_py), 0);
    chk({"R1 ", when}, "p2 de", int'(c_de), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1'b1;
    // position p is visible at the negedge after the (p+1)-th posedge
    for (int p = 0; p < 40000; p++) begin
      @(negedge clk);
      // small geometry, R9 wrap covered over many frames
      check_pos("small", p, 12, 3, 2, 8, 2, 1, s_hs, s_vs, s_de, s_rq, s_fs,
                int'(s_px), int'(s_py));
      // R8 built-in profiles
      check_pos("prof0", p, 1056, 216, 40, 525, 35, 10, a_hs, a_vs, a_de, a_rq, a_fs,
                int'(a_px), int'(a_py));
      check_pos("prof1", p, 525, 43, 2, 286, 12, 2, b_hs, b_vs, b_de, b_rq, b_fs,
                int'(b_px), int'(b_py));
      check_pos("prof2", p, 528, 108, 20, 262, 20, 2, c_hs, c_vs, c_de, c_rq, c_fs,
                int'(c_px), int'(c_py));
    end
    // mid-run reset returns to the idle state, R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid-run");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule